// File: doc/BRIEF.md
# Processor I/O Port Register Emulator

This block sits beside a plain 6502-family processor and adds the small parallel port that some variants of that processor carry on chip. It watches the processor bus and claims the two lowest memory addresses: address 0 holds a direction register and address 1 holds an output data register, both in place of RAM. Eight port pins are driven from these registers, and a read of either address returns a value onto the data bus.

The write strobe is not taken from the processor. It is built from two system clocks, the main clock and the system-generated phase-2 clock, both sampled on a fast oversampling clock through two-stage synchronizers. A strobe is produced only when phase-2 falls strictly later than the main clock has fallen. A phase-2 fall that comes with the main clock fall or ahead of it produces no strobe, and the write is dropped. Address and write data must be held stable across the phase-2 fall.

Top module: `cpu_port_shim`

## Requirements
- R1: After reset both registers are zero, so `pin_oe` and `pin_o` are 0x00 and every pin is an input.
- R2: A write to address 0x0000 loads the direction register, and `pin_oe` then equals it (bit set = pin driven as an output).
- R3: A write to address 0x0001 loads the data register, and `pin_o` then equals it.
- R4: A write is taken only when the synchronized phase-2 falls one or more fast-clock samples after the synchronized main clock fell. If both fall in the same sample, the registers are unchanged.
- R5: A phase-2 fall that happens while the main clock is still high produces no write.
- R6: Writes to any address other than 0x0000 and 0x0001 (full 16-bit decode, for example 0x0002, 0x0100, 0x8001) change neither register.
- R7: While `rw` is 1 (read) and the address is 0x0000 or 0x0001, `data_oe` is 1 and a read of 0x0000 returns the direction register. For all other addresses, or while `rw` is 0, `data_oe` is 0.
- R8: A read of 0x0001 returns the data register bit for each output pin and the `pin_i` level for each input pin.
- R9: A bus cycle with `rw` at 1 never changes either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi0 | input | 1 | System main clock, sampled |
| phi2 | input | 1 | System-generated phase-2 clock, sampled |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | 1 = read, 0 = write |
| data_in | input | 8 | Processor data bus during writes |
| data_out | output | 8 | Read-back value for the data bus |
| data_oe | output | 1 | Enable for driving the data bus |
| pin_i | input | 8 | Sensed level of the port pins |
| pin_o | output | 8 | Output value of the port pins |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
Bus writes are issued with four clock orderings: phase-2 falling three samples after the main clock, one sample after it, in the same sample, and before it. These orderings separate the valid window from its two rejection cases and from its shortest accepted gap. Address patterns cover both decoded addresses, addresses that differ from them only in high bits, and read cycles. A mixed direction mask combined with a distinct `pin_i` pattern shows, bit by bit, whether read-back takes the latched value or the live pin level.

// File: rtl/cpu_port_shim.sv
module cpu_port_shim #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = '0,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi0,
  input  logic              phi2,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic [PORT_W-1:0] data_in,
  output logic [PORT_W-1:0] data_out,
  output logic              data_oe,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe
);
  logic [2:0] p0_sr, p2_sr;
  logic win;
  logic [PORT_W-1:0] dir_q, dat_q;

  wire p0_fall = p0_sr[2] & ~p0_sr[1];
  wire p0_rise = ~p0_sr[2] & p0_sr[1];
  wire p2_fall = p2_sr[2] & ~p2_sr[1];
  wire wr_stb  = p2_fall & win;
  wire sel_dir = (addr == DIR_ADDR);
  wire sel_dat = (addr == DAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_sr <= '0;
      p2_sr <= '0;
      win   <= 1'b0;
    end else begin
      p0_sr <= {p0_sr[1:0], phi0};
      p2_sr <= {p2_sr[1:0], phi2};
      if (p0_rise || p2_fall) win <= 1'b0;
      else if (p0_fall)       win <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr_stb && !rw) begin
      if (sel_dir) dir_q <= data_in;
      if (sel_dat) dat_q <= data_in;
    end
  end

  assign pin_oe   = dir_q;
  assign pin_o    = dat_q;
  assign data_oe  = rw & (sel_dir | sel_dat);
  assign data_out = !data_oe ? '0 :
                    sel_dir  ? dir_q : ((dat_q & dir_q) | (pin_i & ~dir_q));
endmodule

module cpu_port_shim_chk #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              p0_s,
  input logic              wr_stb,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic [PORT_W-1:0] pin_o,
  input logic [PORT_W-1:0] pin_oe
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (pin_oe == '0 && pin_o == '0));
  // R2
  dir_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(wr_stb && !rw && addr == '0));
  // R3
  dat_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> $past(wr_stb && !rw && addr == 1));
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb);
  // R5
  window_low_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> !p0_s);
  // R9
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rw) |=> ($stable(pin_o) && $stable(pin_oe)));
endmodule

bind cpu_port_shim cpu_port_shim_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .p0_s(p0_sr[1]), .wr_stb(wr_stb), .rw(rw),
  .addr(addr), .pin_o(pin_o), .pin_oe(pin_oe)
);

// File: tb/test_cpu_port_shim.sv
module test_cpu_port_shim;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {addr16, data8, rw1, order2, exp_oe8, exp_o8, req4}
  // order: 0 = phase-2 three samples late, 1 = same sample, 2 = phase-2 first, 3 = one sample late
  localparam logic [46:0] VEC [NV] = '{
    {16'h0000, 8'hF0, 1'b0, 2'd0, 8'hF0, 8'h00, 4'd2},  // R2
    {16'h0001, 8'hA5, 1'b0, 2'd0, 8'hF0, 8'hA5, 4'd3},  // R3
    {16'h0001, 8'h3C, 1'b0, 2'd1, 8'hF0, 8'hA5, 4'd4},  // R4
    {16'h0000, 8'h0F, 1'b0, 2'd2, 8'hF0, 8'hA5, 4'd5},  // R5
    {16'h0002, 8'hFF, 1'b0, 2'd0, 8'hF0, 8'hA5, 4'd6},  // R6
    {16'h0100, 8'h00, 1'b0, 2'd0, 8'hF0, 8'hA5, 4'd6},  // R6
    {16'h8001, 8'h00, 1'b0, 2'd0, 8'hF0, 8'hA5, 4'd6},  // R6
    {16'h0001, 8'h00, 1'b1, 2'd0, 8'hF0, 8'hA5, 4'd9},  // R9
    {16'h0000, 8'h0F, 1'b0, 2'd0, 8'h0F, 8'hA5, 4'd2},  // R2
    {16'h0001, 8'h5A, 1'b0, 2'd3, 8'h0F, 8'h5A, 4'd4}   // R4
  };

  logic clk = 0, rst_n = 0, phi0 = 1, phi2 = 1, rw = 1;
  logic [15:0] addr = 16'hFFFF;
  logic [7:0] data_in = 0, pin_i = 0;
  logic [7:0] data_out, pin_o, pin_oe;
  logic data_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_port_shim i_cpu_port_shim (
    .clk(clk), .rst_n(rst_n), .phi0(phi0), .phi2(phi2), .addr(addr), .rw(rw),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(logic [15:0] a, logic [7:0] d, logic r, logic [1:0] ord);
    @(negedge clk); addr = a; data_in = d; rw = r; phi0 = 1; phi2 = 1;
    repeat (4) @(negedge clk);
    case (ord)
      2'd0: begin phi0 = 0; repeat (3) @(negedge clk); phi2 = 0; end
      2'd1: begin phi0 = 0; phi2 = 0; end
      2'd2: begin phi2 = 0; repeat (3) @(negedge clk); phi0 = 0; end
      default: begin phi0 = 0; @(negedge clk); phi2 = 0; end
    endcase
    repeat (5) @(negedge clk);
  endtask

  task automatic rd(logic [15:0] a);
    @(negedge clk); addr = a; rw = 1; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 o", pin_o, 8'h00);
    pin_i = 8'hFF;
    rd(16'h0001);
    check("R1/R8 all inputs", data_out, 8'hFF);
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][46:31], VEC[i][30:23], VEC[i][22], VEC[i][21:20]);
      check($sformatf("R%0d vec%0d oe", VEC[i][3:0], i), pin_oe, VEC[i][19:12]);
      check($sformatf("R%0d vec%0d o", VEC[i][3:0], i), pin_o, VEC[i][11:4]);
    end
    pin_i = 8'hC3;
    rd(16'h0000);
    check("R7 oe", {7'd0, data_oe}, 8'h01);
    check("R7 dir", data_out, 8'h0F);
    rd(16'h0001);
    check("R8 mix", data_out, 8'hCA);
    rd(16'h0002);
    check("R7 other addr", {7'd0, data_oe}, 8'h00);
    @(negedge clk); addr = 16'h0001; rw = 0; #1;
    check("R7 write cycle", {7'd0, data_oe}, 8'h00);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 rereset oe", pin_oe, 8'h00);
    check("R1 rereset o", pin_o, 8'h00);
    rst_n = 1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule